// File: doc/BRIEF.md
# MII Carrier Sense, Collision and Error-Pin Mapper

This block sits between the coding layers of a 10/100 Ethernet PHY and the MII pins facing the MAC. It takes internal transmit-active and receive-active indications and drives the carrier-sense and collision outputs from them. How it does so depends on a duplex control bit. In half duplex, activity in either direction raises carrier sense, and simultaneous activity is reported as a collision. In full duplex, only receive activity raises carrier sense and collision stays low.

The transmit nibble path forwards the MAC nibble towards the encoder. At 100 Mb/s, a MAC transmit error requests that invalid code symbols be placed on the line. The receive path maps the decoder output onto the MII receive pins. A symbol-mode control turns both error pins into a fifth data bit, so raw 5-bit code groups pass through in each direction. A power-down input holds carrier sense, collision and every receive output inactive, which isolates the MII.

The MII data flow carries a valid qualifier (tx_en / rx_dv) but no ready. Neither side can apply back-pressure, and the block accepts one nibble per clock in each direction. All outputs are registered: each result appears one clock after the inputs that cause it, on tx_clk for the transmit path and on rx_clk for the receive path, carrier sense and collision.

Top module: `mii_sense_collide`

## Requirements
- R1: With the duplex bit at 0 (half duplex) and power-down low, mii_crs is 1 one rx clock after either tx_active or rx_active is 1, and 0 one clock after both are 0.
- R2: With the duplex bit at 1 (full duplex) and power-down low, mii_crs follows rx_active alone, one rx clock later; tx_active has no effect on it.
- R3: In half duplex with power-down low, mii_col is 1 one rx clock after tx_active and rx_active are both 1, stays 1 for every cycle that both remain 1, and is 0 one clock after either drops.
- R4: In full duplex, mii_col is 0 one rx clock later, whatever tx_active and rx_active are.
- R5: With pwr_down at 1, mii_crs, mii_col, mii_rx_dv, mii_rx_er and mii_rxd are all 0 one rx clock later.
- R6: With spd100 at 1 and sym_mode at 0, enc_bad_sym is 1 one tx clock after mac_tx_en and mac_tx_er are both 1, and 0 otherwise. With spd100 at 0, enc_bad_sym stays 0.
- R7: With sym_mode at 1, enc_data[4] equals mac_tx_er and enc_data[3:0] equals mac_txd, one tx clock later, and enc_bad_sym is 0.
- R8: With sym_mode at 0, enc_data[4] is 0 and enc_data[3:0] equals mac_txd one tx clock later. enc_valid equals mac_tx_en one tx clock later in both modes.
- R9: With sym_mode at 0 and power-down low, one rx clock later mii_rx_dv equals dec_valid, mii_rxd equals dec_data[3:0] and mii_rx_er equals dec_bad; dec_data[4] has no effect.
- R10: With sym_mode at 1 and power-down low, mii_rx_er equals dec_data[4] one rx clock later and dec_bad has no effect; mii_rx_dv and mii_rxd behave as in R9.
- R11: While rst_n is 0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tx | input | 1 | Transmit nibble clock (25 MHz / 2.5 MHz) |
| clk_rx | input | 1 | Receive nibble clock; also times crs/col |
| rst_n | input | 1 | Asynchronous active-low reset |
| fdx | input | 1 | Duplex control: 1 full, 0 half |
| spd100 | input | 1 | 1 for 100 Mb/s, 0 for 10 Mb/s |
| sym_mode | input | 1 | 1 selects 5-bit symbol mode |
| pwr_down | input | 1 | Power-down, isolates MII outputs |
| tx_active | input | 1 | Transmit medium non-idle |
| rx_active | input | 1 | Receive medium non-idle |
| mac_txd | input | 4 | Transmit nibble from MAC |
| mac_tx_en | input | 1 | Transmit nibble valid |
| mac_tx_er | input | 1 | Transmit error, or bit 4 in symbol mode |
| enc_data | output | 5 | Symbol or nibble to encoder |
| enc_valid | output | 1 | enc_data valid |
| enc_bad_sym | output | 1 | Request to send invalid code symbols |
| dec_data | input | 5 | Symbol or nibble from decoder |
| dec_valid | input | 1 | dec_data valid |
| dec_bad | input | 1 | Decoder saw an invalid symbol |
| mii_rxd | output | 4 | Receive nibble to MAC |
| mii_rx_dv | output | 1 | Receive data valid |
| mii_rx_er | output | 1 | Receive error, or bit 4 in symbol mode |
| mii_crs | output | 1 | Carrier sense |
| mii_col | output | 1 | Collision |

## Verification
Every result here is due exactly one clock after its cause: the transmit outputs after a tx_clk edge, and the receive outputs, carrier sense and collision after an rx_clk edge. The bench applies a new set of inputs on a falling edge and computes the expected outputs from those inputs alone. It then samples one time unit after the following rising edge, so each sample sees the output of exactly one register update. Directed steps cover duplex switching mid-collision, power-down during traffic and error handling at both speeds. Seeded random steps then mix all control bits on every cycle.

// File: rtl/mii_sc_pkg.sv
package mii_sc_pkg;

  localparam int unsigned NIB_W_DEF = 4;

  // carrier is raised by receive always, by transmit only in half duplex
  function automatic logic carrier_on(input logic full_dup, input logic tx_a,
                                      input logic rx_a);
    return rx_a | (~full_dup & tx_a);
  endfunction

  function automatic logic collide_on(input logic full_dup, input logic tx_a,
                                      input logic rx_a);
    return ~full_dup & tx_a & rx_a;
  endfunction

  // error pin doubles as the top data bit in symbol mode
  function automatic logic err_pin(input logic sym, input logic top_bit,
                                   input logic err);
    return sym ? top_bit : err;
  endfunction

endpackage

// File: rtl/mii_sc_sense.sv
module mii_sc_sense #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fdx,
  input  logic pwr_down,
  input  logic tx_act,
  input  logic rx_act,
  output logic crs,
  output logic col
);
  logic crs_d, col_d;

  always_comb begin
    crs_d = ~pwr_down & mii_sc_pkg::carrier_on(fdx, tx_act, rx_act);
    col_d = ~pwr_down & mii_sc_pkg::collide_on(fdx, tx_act, rx_act);
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          crs <= 1'b0;
          col <= 1'b0;
        end else begin
          crs <= crs_d;
          col <= col_d;
        end
      end
    end else begin : g_comb
      assign crs = rst_n & crs_d;
      assign col = rst_n & col_d;
    end
  endgenerate
endmodule

// File: rtl/mii_sc_txmap.sv
module mii_sc_txmap #(
  parameter int unsigned NIB_W = 4,
  localparam int unsigned SYM_W = NIB_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spd100,
  input  logic             sym_mode,
  input  logic [NIB_W-1:0] txd,
  input  logic             tx_en,
  input  logic             tx_er,
  output logic [SYM_W-1:0] enc_data,
  output logic             enc_valid,
  output logic             enc_bad_sym
);
  logic             top_bit;
  logic             bad_d;

  always_comb begin
    top_bit = sym_mode & tx_er;
    bad_d   = ~sym_mode & spd100 & tx_en & tx_er;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_data    <= '0;
      enc_valid   <= 1'b0;
      enc_bad_sym <= 1'b0;
    end else begin
      enc_data    <= {top_bit, txd};
      enc_valid   <= tx_en;
      enc_bad_sym <= bad_d;
    end
  end
endmodule

// File: rtl/mii_sc_rxmap.sv
module mii_sc_rxmap #(
  parameter int unsigned NIB_W = 4,
  localparam int unsigned SYM_W = NIB_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_mode,
  input  logic             pwr_down,
  input  logic [SYM_W-1:0] dec_data,
  input  logic             dec_valid,
  input  logic             dec_bad,
  output logic [NIB_W-1:0] rxd,
  output logic             rx_dv,
  output logic             rx_er
);
  logic [NIB_W-1:0] nib_d;
  logic             er_d;
  logic             dv_d;

  always_comb begin
    nib_d = pwr_down ? '0 : dec_data[NIB_W-1:0];
    dv_d  = ~pwr_down & dec_valid;
    er_d  = ~pwr_down & mii_sc_pkg::err_pin(sym_mode, dec_data[SYM_W-1], dec_bad);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd   <= '0;
      rx_dv <= 1'b0;
      rx_er <= 1'b0;
    end else begin
      rxd   <= nib_d;
      rx_dv <= dv_d;
      rx_er <= er_d;
    end
  end
endmodule

// File: rtl/mii_sense_collide.sv
module mii_sense_collide #(
  parameter int unsigned NIB_W   = mii_sc_pkg::NIB_W_DEF,
  parameter bit          CRS_REG = 1'b1,
  localparam int unsigned SYM_W  = NIB_W + 1
) (
  input  logic             clk_tx,
  input  logic             clk_rx,
  input  logic             rst_n,
  input  logic             fdx,
  input  logic             spd100,
  input  logic             sym_mode,
  input  logic             pwr_down,
  input  logic             tx_active,
  input  logic             rx_active,
  input  logic [NIB_W-1:0] mac_txd,
  input  logic             mac_tx_en,
  input  logic             mac_tx_er,
  output logic [SYM_W-1:0] enc_data,
  output logic             enc_valid,
  output logic             enc_bad_sym,
  input  logic [SYM_W-1:0] dec_data,
  input  logic             dec_valid,
  input  logic             dec_bad,
  output logic [NIB_W-1:0] mii_rxd,
  output logic             mii_rx_dv,
  output logic             mii_rx_er,
  output logic             mii_crs,
  output logic             mii_col
);

  mii_sc_sense #(.REG_OUT(CRS_REG)) sense_i (
    .clk      (clk_rx),
    .rst_n    (rst_n),
    .fdx      (fdx),
    .pwr_down (pwr_down),
    .tx_act   (tx_active),
    .rx_act   (rx_active),
    .crs      (mii_crs),
    .col      (mii_col)
  );

  mii_sc_txmap #(.NIB_W(NIB_W)) txmap_i (
    .clk         (clk_tx),
    .rst_n       (rst_n),
    .spd100      (spd100),
    .sym_mode    (sym_mode),
    .txd         (mac_txd),
    .tx_en       (mac_tx_en),
    .tx_er       (mac_tx_er),
    .enc_data    (enc_data),
    .enc_valid   (enc_valid),
    .enc_bad_sym (enc_bad_sym)
  );

  mii_sc_rxmap #(.NIB_W(NIB_W)) rxmap_i (
    .clk       (clk_rx),
    .rst_n     (rst_n),
    .sym_mode  (sym_mode),
    .pwr_down  (pwr_down),
    .dec_data  (dec_data),
    .dec_valid (dec_valid),
    .dec_bad   (dec_bad),
    .rxd       (mii_rxd),
    .rx_dv     (mii_rx_dv),
    .rx_er     (mii_rx_er)
  );

endmodule

// File: rtl/mii_sense_collide_chk.sv
module mii_sense_collide_chk #(
  parameter int unsigned NIB_W   = 4,
  parameter bit          CRS_REG = 1'b1,
  localparam int unsigned SYM_W  = NIB_W + 1
) (
  input logic             clk_tx,
  input logic             clk_rx,
  input logic             rst_n,
  input logic             fdx,
  input logic             spd100,
  input logic             sym_mode,
  input logic             pwr_down,
  input logic             tx_active,
  input logic             rx_active,
  input logic             mac_tx_en,
  input logic             mac_tx_er,
  input logic [SYM_W-1:0] enc_data,
  input logic             enc_bad_sym,
  input logic             mii_rx_dv,
  input logic             mii_rx_er,
  input logic             mii_crs,
  input logic             mii_col
);

  generate
    if (CRS_REG) begin : g_reg_props
      assert_hdx_crs_R1: assert property (@(posedge clk_rx) disable iff (!rst_n)
        (!fdx && !pwr_down && (tx_active || rx_active)) |=> mii_crs);
      assert_fdx_crs_R2: assert property (@(posedge clk_rx) disable iff (!rst_n)
        (fdx && !rx_active) |=> !mii_crs);
      assert_col_on_R3: assert property (@(posedge clk_rx) disable iff (!rst_n)
        (!fdx && !pwr_down && tx_active && rx_active) |=> mii_col);
      assert_fdx_nocol_R4: assert property (@(posedge clk_rx) disable iff (!rst_n)
        fdx |=> !mii_col);
      assert_pwrdn_quiet_R5: assert property (@(posedge clk_rx) disable iff (!rst_n)
        pwr_down |=> (!mii_crs && !mii_col && !mii_rx_dv && !mii_rx_er));
    end else begin : g_comb_props
      assert_hdx_crs_R1: assert property (@(posedge clk_rx) disable iff (!rst_n)
        (!fdx && !pwr_down && (tx_active || rx_active)) |-> mii_crs);
      assert_fdx_nocol_R4: assert property (@(posedge clk_rx) disable iff (!rst_n)
        fdx |-> !mii_col);
    end
  endgenerate

  assert_badsym_R6: assert property (@(posedge clk_tx) disable iff (!rst_n)
    (spd100 && !sym_mode && mac_tx_en && mac_tx_er) |=> enc_bad_sym);
  assert_sym_nobad_R7: assert property (@(posedge clk_tx) disable iff (!rst_n)
    sym_mode |=> !enc_bad_sym);
  assert_top_zero_R8: assert property (@(posedge clk_tx) disable iff (!rst_n)
    !sym_mode |=> !enc_data[SYM_W-1]);
  assert_col_implies_crs_R3: assert property (@(posedge clk_rx) disable iff (!rst_n)
    mii_col |-> mii_crs);

endmodule

bind mii_sense_collide mii_sense_collide_chk #(.NIB_W(NIB_W), .CRS_REG(CRS_REG)) chk_i (
  .clk_tx      (clk_tx),
  .clk_rx      (clk_rx),
  .rst_n       (rst_n),
  .fdx         (fdx),
  .spd100      (spd100),
  .sym_mode    (sym_mode),
  .pwr_down    (pwr_down),
  .tx_active   (tx_active),
  .rx_active   (rx_active),
  .mac_tx_en   (mac_tx_en),
  .mac_tx_er   (mac_tx_er),
  .enc_data    (enc_data),
  .enc_bad_sym (enc_bad_sym),
  .mii_rx_dv   (mii_rx_dv),
  .mii_rx_er   (mii_rx_er),
  .mii_crs     (mii_crs),
  .mii_col     (mii_col)
);

// File: tb/mii_sense_collide_tb.sv
module mii_sense_collide_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rst_n, fdx, spd100, sym_mode, pwr_down, tx_active, rx_active;
  logic [3:0] mac_txd;
  logic       mac_tx_en, mac_tx_er;
  logic [4:0] enc_data;
  logic       enc_valid, enc_bad_sym;
  logic [4:0] dec_data;
  logic       dec_valid, dec_bad;
  logic [3:0] mii_rxd;
  logic       mii_rx_dv, mii_rx_er, mii_crs, mii_col;

  int total = 0;
  int bad = 0;

  mii_sense_collide dut_i (
    .clk_tx(clk), .clk_rx(clk), .rst_n(rst_n), .fdx(fdx), .spd100(spd100),
    .sym_mode(sym_mode), .pwr_down(pwr_down), .tx_active(tx_active),
    .rx_active(rx_active), .mac_txd(mac_txd), .mac_tx_en(mac_tx_en),
    .mac_tx_er(mac_tx_er), .enc_data(enc_data), .enc_valid(enc_valid),
    .enc_bad_sym(enc_bad_sym), .dec_data(dec_data), .dec_valid(dec_valid),
    .dec_bad(dec_bad), .mii_rxd(mii_rxd), .mii_rx_dv(mii_rx_dv),
    .mii_rx_er(mii_rx_er), .mii_crs(mii_crs), .mii_col(mii_col)
  );

  // expected values from the requirements
  function automatic logic f_crs(logic fd, logic pd, logic ta, logic ra);
    if (pd) return 1'b0;                // R5
    return fd ? ra : (ta | ra);         // R2 / R1
  endfunction
  function automatic logic f_col(logic fd, logic pd, logic ta, logic ra);
    return !pd && !fd && ta && ra;      // R3 / R4
  endfunction
  function automatic logic [4:0] f_enc(logic sm, logic er, logic [3:0] d);
    return {sm & er, d};                // R7 / R8
  endfunction
  function automatic logic f_bad(logic sp, logic sm, logic en, logic er);
    return sp && !sm && en && er;       // R6
  endfunction
  function automatic logic f_rxer(logic pd, logic sm, logic [4:0] d, logic b);
    if (pd) return 1'b0;
    return sm ? d[4] : b;               // R10 / R9
  endfunction

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // drive current stimulus variables on a falling edge, check after the next rising edge
  task automatic step();
    logic e_crs, e_col, e_bad, e_val, e_dv, e_er;
    logic [4:0] e_enc;
    logic [3:0] e_rxd;
    e_crs = f_crs(fdx, pwr_down, tx_active, rx_active);
    e_col = f_col(fdx, pwr_down, tx_active, rx_active);
    e_enc = f_enc(sym_mode, mac_tx_er, mac_txd);
    e_bad = f_bad(spd100, sym_mode, mac_tx_en, mac_tx_er);
    e_val = mac_tx_en;
    e_dv  = !pwr_down && dec_valid;
    e_rxd = pwr_down ? 4'h0 : dec_data[3:0];
    e_er  = f_rxer(pwr_down, sym_mode, dec_data, dec_bad);
    @(posedge clk);
    #1;
    chk("R1/R2 crs", {4'b0, mii_crs}, {4'b0, e_crs});
    chk("R3/R4 col", {4'b0, mii_col}, {4'b0, e_col});
    chk("R7/R8 enc_data", enc_data, e_enc);
    chk("R8 enc_valid", {4'b0, enc_valid}, {4'b0, e_val});
    chk("R6 enc_bad_sym", {4'b0, enc_bad_sym}, {4'b0, e_bad});
    chk("R9 rx_dv", {4'b0, mii_rx_dv}, {4'b0, e_dv});
    chk("R9 rxd", {1'b0, mii_rxd}, {1'b0, e_rxd});
    chk("R9/R10 rx_er", {4'b0, mii_rx_er}, {4'b0, e_er});
    @(negedge clk);
  endtask

  task automatic quiet();
    fdx = 0; spd100 = 1; sym_mode = 0; pwr_down = 0; tx_active = 0; rx_active = 0;
    mac_txd = 0; mac_tx_en = 0; mac_tx_er = 0; dec_data = 0; dec_valid = 0; dec_bad = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    rst_n = 0;
    quiet();
    tx_active = 1; rx_active = 1; dec_valid = 1; dec_bad = 1; mac_tx_en = 1; mac_tx_er = 1;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk("R11 reset", {mii_crs, mii_col, enc_valid, enc_bad_sym, mii_rx_dv}, 5'b0);
    chk("R11 reset data", enc_data | {1'b0, mii_rxd} | {4'b0, mii_rx_er}, 5'b0);
    @(negedge clk);
    quiet();
    rst_n = 1;

    // R1 half duplex: tx only, rx only, idle
    tx_active = 1; step();
    tx_active = 0; rx_active = 1; step();
    rx_active = 0; step();
    // R3 collision held for several cycles, then ends
    tx_active = 1; rx_active = 1; repeat (4) step();
    rx_active = 0; step();
    // R4 / R2 switch to full duplex mid collision
    rx_active = 1; step();
    fdx = 1; step();
    rx_active = 0; step();      // R2: tx alone does not raise crs
    // R5 power-down during traffic
    fdx = 0; rx_active = 1; dec_valid = 1; dec_data = 5'h1f; dec_bad = 1; pwr_down = 1; step();
    pwr_down = 0; step();
    // R6 tx error at 100 and 10 Mb/s, and without tx_en
    quiet(); mac_tx_en = 1; mac_tx_er = 1; mac_txd = 4'ha; step();
    spd100 = 0; step();
    spd100 = 1; mac_tx_en = 0; step();
    // R7 symbol mode tx, R10 symbol mode rx
    sym_mode = 1; mac_tx_en = 1; mac_tx_er = 1; mac_txd = 4'h5; step();
    dec_valid = 1; dec_data = 5'h10; dec_bad = 0; step();
    dec_data = 5'h03; dec_bad = 1; step();
    // R9 normal rx: bit 4 ignored, error follows dec_bad
    sym_mode = 0; dec_data = 5'h1c; dec_bad = 0; step();
    dec_bad = 1; step();

    // seeded random mix
    for (int i = 0; i < 3000; i++) begin
      fdx       = 1'($urandom);
      spd100    = 1'($urandom);
      sym_mode  = 1'($urandom);
      pwr_down  = (($urandom % 8) == 0);
      tx_active = 1'($urandom);
      rx_active = 1'($urandom);
      mac_txd   = 4'($urandom);
      mac_tx_en = 1'($urandom);
      mac_tx_er = 1'($urandom);
      dec_data  = 5'($urandom);
      dec_valid = 1'($urandom);
      dec_bad   = 1'($urandom);
      step();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule